// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block sits beside the instruction decoder of a small 32-bit core and runs the entry and exit of every interrupt, software interrupt, privilege trap and system call. On entry it saves the instruction pointer, stack pointer and flag word into three control-status registers, all at once. It then reads the handler address from a 256-entry vector table. Finally it loads the core with the new pointer and a flag word that selects supervisor mode with interrupts masked. On return it reloads all three values from the control-status registers in one step. It also stops the core clock when software sets the stop flag. With interrupts enabled the clock restarts on the next request. With interrupts disabled the core stays stopped until reset.

The flag word bit positions are fixed: bit 16 is interrupt enable, bit 17 is user mode and bit 19 is clock stop. The vector table is read through a port with one cycle of latency: the index is presented with `idt_rd` and the entry is returned on `idt_data` in the next cycle. While `busy` is high, the core pipeline must stall and present no new instruction.

The states are IDLE (the core is running), ENTER (the context is saved and the table read is issued), VECTOR (the core is loaded with the handler), RETURN (the saved context is reloaded), SLEEP (the clock is stopped until an interrupt arrives) and HALT (the clock is stopped until reset). The transitions are as follows. IDLE goes to ENTER on an accepted request, fault, software interrupt or system call. IDLE goes to RETURN on a permitted return. IDLE goes to SLEEP or HALT when the stop bit is set. ENTER always goes to VECTOR. VECTOR and RETURN always go back to IDLE. SLEEP goes to ENTER on an interrupt request. HALT stays in HALT.

Top module: `trap_seq`

## Requirements
- R1: After reset the sequencer is idle: `busy` and `ld_en` are 0, `clk_en` is 1, and `cs_save`, `cs_restore` and `idt_rd` are all 0.
- R2: In the cycle after an entry is accepted, `cs_save` and `idt_rd` are 1. In that cycle `sv_ip` and `sv_sp` carry the pointers sampled at acceptance, `sv_flg` carries the sampled flag word with bit 19 forced to 0, and `idt_idx` carries the selected vector.
- R3: In the cycle after that, `ld_en` is 1 and `cs_restore` is 0. `new_ip` equals `idt_data`, `new_sp` equals the saved stack pointer, and `new_flg` equals the saved flag word with bits 16, 17 and 19 cleared.
- R4: An external request (`irq_req`) is accepted only in a cycle with `at_boundary`=1 and flag bit 16=1, and it uses `irq_vec` as its vector. Otherwise it has no effect.
- R5: A system call (`op_scall`) enters through the fixed vector SCALL_VEC (default 5) in both user and supervisor mode.
- R6: A software interrupt (`op_int`) or return (`op_iret`) issued while flag bit 17 is 1 does not execute. Instead it enters through the fault vector FAULT_VEC (default 6). A software interrupt in supervisor mode enters through `op_vec`.
- R7: A permitted return is followed by one cycle in which `ld_en` and `cs_restore` are 1, and `new_ip`, `new_sp` and `new_flg` equal `cs0_in`, `cs1_in` and `cs2_in`.
- R8: `busy` is high for exactly two cycles per entry and one cycle per return. Strobes and requests that arrive while `busy` is high have no effect.
- R9: At a boundary with no other event, flag bits 19 and 16 both set cause `clk_en` to drop in the next cycle. It stays low until `irq_req` is 1. That request then starts an entry with vector `irq_vec`, with no boundary needed.
- R10: At a boundary with no other event, flag bit 19 set and bit 16 clear cause `clk_en` to drop for good. Requests are ignored, and only reset restores `clk_en`.
- R11: Events at a boundary are served in this order: external request, privilege fault, software interrupt, system call, return, clock stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| at_boundary | input | 1 | Core is at an instruction boundary |
| irq_req | input | 1 | External interrupt request |
| irq_vec | input | 8 | Vector of the external request |
| op_int | input | 1 | Decoded software interrupt |
| op_scall | input | 1 | Decoded system call |
| op_iret | input | 1 | Decoded return from interrupt |
| op_vec | input | 8 | Immediate vector of the software interrupt |
| cur_ip | input | 32 | Current instruction pointer |
| cur_sp | input | 32 | Current stack pointer |
| cur_flg | input | 32 | Current flag word |
| cs0_in | input | 32 | Saved instruction pointer |
| cs1_in | input | 32 | Saved stack pointer |
| cs2_in | input | 32 | Saved flag word |
| idt_data | input | 32 | Vector table entry, one cycle after idt_rd |
| idt_rd | output | 1 | Vector table read strobe |
| idt_idx | output | 8 | Vector table index |
| cs_save | output | 1 | Write strobe for all three control-status registers |
| sv_ip | output | 32 | Instruction pointer to save |
| sv_sp | output | 32 | Stack pointer to save |
| sv_flg | output | 32 | Flag word to save |
| cs_restore | output | 1 | Load taken from the control-status registers |
| ld_en | output | 1 | Load strobe for the core's IP, SP and FLG |
| new_ip | output | 32 | Instruction pointer to load |
| new_sp | output | 32 | Stack pointer to load |
| new_flg | output | 32 | Flag word to load |
| busy | output | 1 | Pipeline stall request |
| clk_en | output | 1 | Core clock enable |

## Verification
A wrong state shows up within one cycle at the ports. `busy` and the save and load strobes are all decoded directly from the state, so a missed or extra transition changes them at the very next clock edge. A wrong vector selection or a wrongly captured context stays hidden until ENTER, where it appears on `idt_idx` and `sv_*`. It then shows up again one cycle later on `new_ip` and `new_flg`. A wrong stop decision shows up at once on `clk_en`, and a HALT entered in error persists until reset.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    localparam int FB_IE   = 16;
    localparam int FB_UM   = 17;
    localparam int FB_STOP = 19;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ENTER, ST_VECTOR, ST_RETURN, ST_SLEEP, ST_HALT
    } seq_state_e;

    typedef enum logic [2:0] {
        CZ_NONE, CZ_IRQ, CZ_FAULT, CZ_SOFT, CZ_SCALL, CZ_RET, CZ_STOP
    } cause_e;
endpackage

// File: rtl/trap_cause_arb.sv
module trap_cause_arb
    import trap_seq_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int SCALL_VEC = 5,
    parameter int FAULT_VEC = 6
) (
    input  logic             at_boundary,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             op_int,
    input  logic             op_scall,
    input  logic             op_iret,
    input  logic [VEC_W-1:0] op_vec,
    input  logic             flg_ie,
    input  logic             flg_um,
    input  logic             flg_stop,
    output cause_e           cause,
    output logic [VEC_W-1:0] vec
);
    localparam logic [VEC_W-1:0] SC_V = VEC_W'(SCALL_VEC);
    localparam logic [VEC_W-1:0] FT_V = VEC_W'(FAULT_VEC);

    always_comb begin
        cause = CZ_NONE;
        vec   = '0;
        if (at_boundary) begin
            if (irq_req && flg_ie) begin
                cause = CZ_IRQ;
                vec   = irq_vec;
            end else if ((op_int || op_iret) && flg_um) begin
                cause = CZ_FAULT;
                vec   = FT_V;
            end else if (op_int) begin
                cause = CZ_SOFT;
                vec   = op_vec;
            end else if (op_scall) begin
                cause = CZ_SCALL;
                vec   = SC_V;
            end else if (op_iret) begin
                cause = CZ_RET;
            end else if (flg_stop) begin
                cause = CZ_STOP;
            end
        end
    end
endmodule

// File: rtl/trap_ctx_reg.sv
module trap_ctx_reg
    import trap_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [XLEN-1:0]  in_ip,
    input  logic [XLEN-1:0]  in_sp,
    input  logic [XLEN-1:0]  in_flg,
    input  logic [VEC_W-1:0] in_vec,
    output logic [XLEN-1:0]  ctx_ip,
    output logic [XLEN-1:0]  ctx_sp,
    output logic [XLEN-1:0]  ctx_flg,
    output logic [VEC_W-1:0] ctx_vec
);
    localparam logic [XLEN-1:0] STOP_M = XLEN'(1) << FB_STOP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_ip  <= '0;
            ctx_sp  <= '0;
            ctx_flg <= '0;
            ctx_vec <= '0;
        end else if (cap) begin
            ctx_ip  <= in_ip;
            ctx_sp  <= in_sp;
            ctx_flg <= in_flg & ~STOP_M;
            ctx_vec <= in_vec;
        end
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int VEC_W     = 8,
    parameter int SCALL_VEC = 5,
    parameter int FAULT_VEC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             at_boundary,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             op_int,
    input  logic             op_scall,
    input  logic             op_iret,
    input  logic [VEC_W-1:0] op_vec,
    input  logic [XLEN-1:0]  cur_ip,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  cur_flg,
    input  logic [XLEN-1:0]  cs0_in,
    input  logic [XLEN-1:0]  cs1_in,
    input  logic [XLEN-1:0]  cs2_in,
    input  logic [XLEN-1:0]  idt_data,
    output logic             idt_rd,
    output logic [VEC_W-1:0] idt_idx,
    output logic             cs_save,
    output logic [XLEN-1:0]  sv_ip,
    output logic [XLEN-1:0]  sv_sp,
    output logic [XLEN-1:0]  sv_flg,
    output logic             cs_restore,
    output logic             ld_en,
    output logic [XLEN-1:0]  new_ip,
    output logic [XLEN-1:0]  new_sp,
    output logic [XLEN-1:0]  new_flg,
    output logic             busy,
    output logic             clk_en
);
    localparam logic [XLEN-1:0] ENTRY_CLR =
        (XLEN'(1) << FB_IE) | (XLEN'(1) << FB_UM) | (XLEN'(1) << FB_STOP);

    seq_state_e       state, nxt;
    cause_e           cause;
    logic [VEC_W-1:0] arb_vec, cap_vec;
    logic             cap;
    logic [XLEN-1:0]  ctx_ip, ctx_sp, ctx_flg;
    logic [VEC_W-1:0] ctx_vec;

    trap_cause_arb #(
        .VEC_W(VEC_W), .SCALL_VEC(SCALL_VEC), .FAULT_VEC(FAULT_VEC)
    ) u_arb (
        .at_boundary(at_boundary),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .op_int     (op_int),
        .op_scall   (op_scall),
        .op_iret    (op_iret),
        .op_vec     (op_vec),
        .flg_ie     (cur_flg[FB_IE]),
        .flg_um     (cur_flg[FB_UM]),
        .flg_stop   (cur_flg[FB_STOP]),
        .cause      (cause),
        .vec        (arb_vec)
    );

    assign cap     = (nxt == ST_ENTER);
    assign cap_vec = (state == ST_SLEEP) ? irq_vec : arb_vec;

    trap_ctx_reg #(.XLEN(XLEN), .VEC_W(VEC_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .in_ip  (cur_ip),
        .in_sp  (cur_sp),
        .in_flg (cur_flg),
        .in_vec (cap_vec),
        .ctx_ip (ctx_ip),
        .ctx_sp (ctx_sp),
        .ctx_flg(ctx_flg),
        .ctx_vec(ctx_vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                unique case (cause)
                    CZ_IRQ, CZ_FAULT, CZ_SOFT, CZ_SCALL: nxt = ST_ENTER;
                    CZ_RET:  nxt = ST_RETURN;
                    CZ_STOP: nxt = cur_flg[FB_IE] ? ST_SLEEP : ST_HALT;
                    default: nxt = ST_IDLE;
                endcase
            end
            ST_ENTER:  nxt = ST_VECTOR;
            ST_VECTOR: nxt = ST_IDLE;
            ST_RETURN: nxt = ST_IDLE;
            ST_SLEEP:  nxt = irq_req ? ST_ENTER : ST_SLEEP;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        idt_rd     = 1'b0;
        idt_idx    = '0;
        cs_save    = 1'b0;
        sv_ip      = '0;
        sv_sp      = '0;
        sv_flg     = '0;
        cs_restore = 1'b0;
        ld_en      = 1'b0;
        new_ip     = '0;
        new_sp     = '0;
        new_flg    = '0;
        busy       = 1'b0;
        clk_en     = 1'b1;
        unique case (state)
            ST_ENTER: begin
                busy    = 1'b1;
                cs_save = 1'b1;
                sv_ip   = ctx_ip;
                sv_sp   = ctx_sp;
                sv_flg  = ctx_flg;
                idt_rd  = 1'b1;
                idt_idx = ctx_vec;
            end
            ST_VECTOR: begin
                busy    = 1'b1;
                ld_en   = 1'b1;
                new_ip  = idt_data;
                new_sp  = ctx_sp;
                new_flg = ctx_flg & ~ENTRY_CLR;
            end
            ST_RETURN: begin
                busy       = 1'b1;
                ld_en      = 1'b1;
                cs_restore = 1'b1;
                new_ip     = cs0_in;
                new_sp     = cs1_in;
                new_flg    = cs2_in;
            end
            ST_SLEEP, ST_HALT: clk_en = 1'b0;
            default: ;
        endcase
    end

    // R2 R3
    save_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_save |=> (ld_en && !cs_restore));

    // R3
    entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !cs_restore) |-> (!new_flg[FB_IE] && !new_flg[FB_UM] && !new_flg[FB_STOP]));

    // R2
    saved_stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_save |-> !sv_flg[FB_STOP]);

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_save, ld_en}));

    // R8
    busy_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> clk_en);

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT && !clk_en));

    // R9
    sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && irq_req) |=> cs_save);
endmodule

// File: tb/tb_trap_seq.sv
module tb_trap_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 0, irq_req = 0, op_int = 0, op_scall = 0, op_iret = 0;
    logic [7:0]  irq_vec = 0, op_vec = 0;
    logic [31:0] cur_ip = 32'h100, cur_sp = 32'h8000, cur_flg = 0;
    logic [31:0] cs0_in = 32'h1111_0000, cs1_in = 32'h2222_0000, cs2_in = 32'h0003_000F;
    logic [31:0] idt_data = 0;
    logic        idt_rd, cs_save, cs_restore, ld_en, busy, clk_en;
    logic [7:0]  idt_idx;
    logic [31:0] sv_ip, sv_sp, sv_flg, new_ip, new_sp, new_flg;

    int total = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    int          ms;
    logic [31:0] m_ip, m_sp, m_flg;
    logic [7:0]  m_vec;

    always #2 clk = ~clk;

    trap_seq dut (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary),
        .irq_req(irq_req), .irq_vec(irq_vec), .op_int(op_int),
        .op_scall(op_scall), .op_iret(op_iret), .op_vec(op_vec),
        .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flg(cur_flg),
        .cs0_in(cs0_in), .cs1_in(cs1_in), .cs2_in(cs2_in),
        .idt_data(idt_data), .idt_rd(idt_rd), .idt_idx(idt_idx),
        .cs_save(cs_save), .sv_ip(sv_ip), .sv_sp(sv_sp), .sv_flg(sv_flg),
        .cs_restore(cs_restore), .ld_en(ld_en), .new_ip(new_ip),
        .new_sp(new_sp), .new_flg(new_flg), .busy(busy), .clk_en(clk_en)
    );

    function automatic logic [31:0] table_entry(input logic [7:0] i);
        return 32'hA000_0000 | (32'(i) << 4);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(tag, "busy", 32'(busy), 32'(ms == 1 || ms == 2 || ms == 3));
        chk(tag, "clk_en", 32'(clk_en), 32'(!(ms == 4 || ms == 5)));
        chk(tag, "cs_save", 32'(cs_save), 32'(ms == 1));
        chk(tag, "idt_rd", 32'(idt_rd), 32'(ms == 1));
        chk(tag, "ld_en", 32'(ld_en), 32'(ms == 2 || ms == 3));
        chk(tag, "cs_restore", 32'(cs_restore), 32'(ms == 3));
        if (ms == 1) begin
            chk(tag, "idt_idx", 32'(idt_idx), 32'(m_vec));
            chk(tag, "sv_ip", sv_ip, m_ip);
            chk(tag, "sv_sp", sv_sp, m_sp);
            chk(tag, "sv_flg", sv_flg, m_flg);
        end
        if (ms == 2) begin
            chk(tag, "new_ip", new_ip, table_entry(m_vec));
            chk(tag, "new_sp", new_sp, m_sp);
            chk(tag, "new_flg", new_flg, m_flg & ~32'h000B_0000);
        end
        if (ms == 3) begin
            chk(tag, "new_ip", new_ip, cs0_in);
            chk(tag, "new_sp", new_sp, cs1_in);
            chk(tag, "new_flg", new_flg, cs2_in);
        end
    endtask

    task automatic capture(input logic [7:0] v);
        m_ip = cur_ip; m_sp = cur_sp; m_flg = cur_flg & ~32'h0008_0000; m_vec = v;
    endtask

    // one clock: drive at negedge, compare, advance model past posedge
    task automatic cyc(input logic b, input logic irq, input logic [7:0] iv,
                       input logic oi, input logic os, input logic orr,
                       input logic [7:0] ov, input logic [31:0] flg);
        int nx;
        at_boundary = b; irq_req = irq; irq_vec = iv;
        op_int = oi; op_scall = os; op_iret = orr; op_vec = ov; cur_flg = flg;
        #1;
        compare();
        nx = ms;
        case (ms)
            0: if (b) begin
                   if (irq && flg[16]) begin nx = 1; capture(iv); end
                   else if ((oi || orr) && flg[17]) begin nx = 1; capture(8'd6); end
                   else if (oi) begin nx = 1; capture(ov); end
                   else if (os) begin nx = 1; capture(8'd5); end
                   else if (orr) nx = 3;
                   else if (flg[19]) nx = flg[16] ? 4 : 5;
               end
            1: nx = 2;
            2: nx = 0;
            3: nx = 0;
            4: if (irq) begin nx = 1; capture(iv); end
            default: nx = ms;
        endcase
        @(posedge clk);
        #1;
        if (ms == 1) idt_data = table_entry(m_vec);
        ms = nx;
        if (clk_en) begin cur_ip = cur_ip + 4; cur_sp = cur_sp - 8; end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [31:0] flg);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, flg);
    endtask

    task automatic do_reset();
        rst_n = 0; ms = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "clk_en", 32'(clk_en), 1);
        chk("R1", "strobes", 32'({cs_save, cs_restore, idt_rd, ld_en}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        tag = "R1"; idle(3, 32'h0);
        // R4: request with interrupts enabled at a boundary
        tag = "R4"; cyc(1, 1, 8'd40, 0, 0, 0, 0, 32'h0001_0000); idle(3, 32'h0001_0000);
        // R4: request ignored with enable clear, and away from a boundary
        cyc(1, 1, 8'd41, 0, 0, 0, 0, 32'h0); cyc(0, 1, 8'd42, 0, 0, 0, 0, 32'h0001_0000);
        idle(2, 32'h0);
        // R6: supervisor software interrupt uses its immediate
        tag = "R6"; cyc(1, 0, 0, 1, 0, 0, 8'd77, 32'h0000_0005); idle(3, 32'h0);
        // R6: user-mode software interrupt traps to fault vector
        cyc(1, 0, 0, 1, 0, 0, 8'd77, 32'h0002_0000); idle(3, 32'h0);
        // R6: user-mode return traps
        cyc(1, 0, 0, 0, 0, 1, 0, 32'h0003_0000); idle(3, 32'h0);
        // R5: system call from user mode and from supervisor mode
        tag = "R5"; cyc(1, 0, 0, 0, 1, 0, 8'd99, 32'h0003_0001); idle(3, 32'h0);
        cyc(1, 0, 0, 0, 1, 0, 8'd99, 32'h0); idle(3, 32'h0);
        // R7: permitted return
        tag = "R7"; cyc(1, 0, 0, 0, 0, 1, 0, 32'h0); idle(2, 32'h0);
        // R8: strobes during busy ignored
        tag = "R8"; cyc(1, 0, 0, 0, 1, 0, 0, 32'h0);
        cyc(1, 1, 8'd50, 1, 1, 0, 8'd51, 32'h0001_0000);
        cyc(1, 1, 8'd52, 0, 0, 1, 0, 32'h0001_0000);
        idle(2, 32'h0);
        cyc(1, 0, 0, 0, 0, 1, 0, 32'h0);
        cyc(1, 1, 8'd53, 1, 0, 0, 8'd54, 32'h0001_0000);
        idle(2, 32'h0);
        // R11: request beats software interrupt; fault beats system call
        tag = "R11"; cyc(1, 1, 8'd200, 1, 0, 0, 8'd33, 32'h0001_0000); idle(3, 32'h0);
        cyc(1, 0, 0, 1, 1, 0, 8'd33, 32'h0002_0000); idle(3, 32'h0);
        cyc(1, 0, 0, 0, 1, 1, 0, 32'h0); idle(3, 32'h0);
        cyc(1, 0, 0, 0, 0, 1, 0, 32'h0009_0000); idle(2, 32'h0);
        // R9: sleep then wake on request
        tag = "R9"; cyc(1, 0, 0, 0, 0, 0, 0, 32'h0009_0000);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 1, 0, 0, 32'h0009_0000);
        cyc(0, 1, 8'd250, 0, 0, 0, 0, 32'h0009_0000); idle(3, 32'h0);
        // R10: halt, requests ignored, reset restores clock
        tag = "R10"; cyc(1, 0, 0, 0, 0, 0, 0, 32'h0008_0000);
        for (int i = 0; i < 4; i++) cyc(1, 1, 8'd7, 1, 0, 0, 0, 32'h0009_0000);
        do_reset();
        chk("R10", "clk_en after reset", 32'(clk_en), 1);
        tag = "R1"; idle(2, 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule